// File: doc/BRIEF.md
# Two-Branch Correlating Direction Predictor

This block predicts whether one particular conditional branch, a branch-if-zero, will be taken. It does not index its predictor by branch address. Instead it uses the most recent resolved outcomes of two earlier branches that come before it in program order. Those two outcome bits pick one of four saturating counters, so the same branch gets a separately trained counter for each combination of its neighbours' behaviour.

The pipeline reports the two earlier branches on the history inputs as they resolve. It reads the prediction from the combinational prediction outputs. When the predicted branch itself resolves, the pipeline reports the outcome on the resolve inputs, and the counter that the current history selects is trained. Resolution is in order. The history seen at resolve time is therefore the history that was used for the prediction, and a history bit written in the same cycle as a resolve only takes effect from the next cycle.

The reset input is asserted asynchronously and released synchronously inside the block. After the external reset is released, the block stays in reset for two more clock edges.

Top module: `bp2c_corr_pred`

## Requirements
- R1: After reset, all four counters hold 1, both history bits hold 0 (not taken), `pred_taken` is 0 and `pred_idx` is 0.
- R2: `pred_idx` equals {second-branch outcome, first-branch outcome}. Value 0 means both were not taken. Value 1 means only the first was taken. Value 2 means only the second was taken. Value 3 means both were taken. `pred_idx` selects the counter that is used.
- R3: When `hist_vld[k]` is high at a clock edge, history bit k takes `hist_taken[k]`. Bit 0 is the first earlier branch and bit 1 is the second. A history bit whose valid is low keeps its value.
- R4: `pred_taken` is 1 exactly when the selected counter holds 2 or 3.
- R5: A resolve with `res_taken`=1 increments the selected counter. A counter already at 3 stays at 3.
- R6: A resolve with `res_taken`=0 decrements the selected counter. A counter already at 0 stays at 0.
- R7: A resolve changes only the counter selected by the history. The other three counters are unchanged, and no counter changes in a cycle without a resolve.
- R8: When a history update and a resolve fall in the same cycle, the resolve trains the counter selected by the history as it was before that edge.
- R9: The effect of a resolve or a history update shows on `pred_taken` and `pred_idx` in the cycle right after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hist_vld | input | 2 | Per earlier branch: outcome reported this cycle |
| hist_taken | input | 2 | Per earlier branch: 1 = taken, 0 = not taken |
| res_vld | input | 1 | The predicted branch resolved this cycle |
| res_taken | input | 1 | Resolved direction of the predicted branch, 1 = taken |
| pred_taken | output | 1 | Predicted direction for the target branch |
| pred_idx | output | 2 | Index of the counter used for the prediction |

## Verification
The hardest case to reach from the ports is a resolve in the same cycle as a change in the history. A design that trains the counter picked by the new history would look correct in any test that keeps the two apart. A directed case therefore changes both history bits and resolves on the same edge, then moves the history back to show which counter moved. The random phase issues history updates and resolves together about half the time. Counter saturation at both ends is also directed: a counter is driven past 3 and past 0 and then stepped back one value, so a wrap-around would show up as a wrong prediction.

// File: rtl/bp2c_pkg.sv
package bp2c_pkg;

  // Branch direction encoding shared by history and counters
  typedef enum logic {
    BR_NOT_TAKEN = 1'b0,
    BR_TAKEN     = 1'b1
  } br_dir_e;

  localparam int unsigned HIST_N_DEF = 2;
  localparam int unsigned CTR_W_DEF  = 2;
  localparam int unsigned CTR_INIT_DEF = 1;

endpackage

// File: rtl/bp2c_rst_sync.sv
module bp2c_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bp2c_hist.sv
module bp2c_hist
  import bp2c_pkg::*;
#(
  parameter int unsigned HIST_N = HIST_N_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_N-1:0] upd_vld,
  input  logic [HIST_N-1:0] upd_taken,
  output logic [HIST_N-1:0] hist_q
);

  for (genvar k = 0; k < HIST_N; k++) begin : g_bit
    br_dir_e dir_q;
    br_dir_e dir_d;
    logic    dir_en;

    assign dir_en = upd_vld[k];

    always_comb begin
      dir_d = dir_q;
      if (dir_en) begin
        dir_d = upd_taken[k] ? BR_TAKEN : BR_NOT_TAKEN;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q <= BR_NOT_TAKEN;
      end else if (dir_en) begin
        dir_q <= dir_d;
      end
    end

    assign hist_q[k] = (dir_q == BR_TAKEN);

    // R3: a reported outcome is captured on the next edge
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_vld[k] |=> (hist_q[k] == $past(upd_taken[k])));

    // R3: without a report the bit holds
    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_vld[k] |=> $stable(hist_q[k]));
  end

endmodule

// File: rtl/bp2c_sat_ctr.sv
module bp2c_sat_ctr
  import bp2c_pkg::*;
#(
  parameter int unsigned CTR_W    = CTR_W_DEF,
  parameter int unsigned CTR_INIT = CTR_INIT_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  br_dir_e          upd_dir,
  output logic [CTR_W-1:0] cnt_q
);

  localparam logic [CTR_W-1:0] CNT_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CNT_MIN = '0;
  localparam logic [CTR_W-1:0] CNT_RST = CTR_W'(CTR_INIT);

  logic [CTR_W-1:0] cnt_d;
  logic             at_max;
  logic             at_min;

  assign at_max = (cnt_q == CNT_MAX);
  assign at_min = (cnt_q == CNT_MIN);

  always_comb begin
    cnt_d = cnt_q;
    if (upd_dir == BR_TAKEN) begin
      if (!at_max) cnt_d = cnt_q + 1'b1;
    end else begin
      if (!at_min) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_RST;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
    end
  end

  p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_dir == BR_TAKEN && !at_max) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_sat_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_dir == BR_TAKEN && at_max) |=> (cnt_q == CNT_MAX));

  p_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_dir == BR_NOT_TAKEN && !at_min) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_sat_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_dir == BR_NOT_TAKEN && at_min) |=> (cnt_q == CNT_MIN));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(cnt_q));

endmodule

// File: rtl/bp2c_corr_pred.sv
module bp2c_corr_pred
  import bp2c_pkg::*;
#(
  parameter int unsigned HIST_N   = HIST_N_DEF,
  parameter int unsigned CTR_W    = CTR_W_DEF,
  parameter int unsigned CTR_INIT = CTR_INIT_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_N-1:0] hist_vld,
  input  logic [HIST_N-1:0] hist_taken,
  input  logic              res_vld,
  input  logic              res_taken,
  output logic              pred_taken,
  output logic [HIST_N-1:0] pred_idx
);

  localparam int unsigned NUM_CTR = 1 << HIST_N;

  logic                          rst_sync_n;
  logic [HIST_N-1:0]             hist_q;
  logic [NUM_CTR-1:0]            ctr_upd_en;
  logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q;
  br_dir_e                       res_dir;

  bp2c_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bp2c_hist #(.HIST_N(HIST_N)) u_hist (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .upd_vld   (hist_vld),
    .upd_taken (hist_taken),
    .hist_q    (hist_q)
  );

  assign res_dir = res_taken ? BR_TAKEN : BR_NOT_TAKEN;

  // Training uses the registered (pre-edge) history: same-cycle
  // history writes only steer later predictions.
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign ctr_upd_en[i] = res_vld && (hist_q == HIST_N'(i));

    bp2c_sat_ctr #(.CTR_W(CTR_W), .CTR_INIT(CTR_INIT)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .upd_en  (ctr_upd_en[i]),
      .upd_dir (res_dir),
      .cnt_q   (ctr_q[i])
    );
  end

  assign pred_idx   = hist_q;
  assign pred_taken = ctr_q[hist_q][CTR_W-1];

  // R7: at most one counter trains per cycle
  p_one_upd_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(ctr_upd_en));

  // R8: a taken resolve moves the counter picked before the edge
  p_old_hist_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_vld && res_taken && ctr_q[pred_idx] != {CTR_W{1'b1}})
      |=> (ctr_q[$past(pred_idx)] == $past(ctr_q[pred_idx]) + 1'b1));

endmodule

// File: tb/bp2c_corr_pred_tb_top.sv
`timescale 1ns/1ps
module bp2c_corr_pred_tb_top;

  logic       clk;
  logic       rst_n;
  logic [1:0] hist_vld;
  logic [1:0] hist_taken;
  logic       res_vld;
  logic       res_taken;
  logic       pred_taken;
  logic [1:0] pred_idx;

  int errors;
  int checks;
  bit finished;

  int      m_ctr [4];
  logic [1:0] m_hist;

  bp2c_corr_pred dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hist_vld   (hist_vld),
    .hist_taken (hist_taken),
    .res_vld    (res_vld),
    .res_taken  (res_taken),
    .pred_taken (pred_taken),
    .pred_idx   (pred_idx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int sat_next(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic bit exp_pred(int c);
    return c >= 2;
  endfunction

  task automatic chk(string req);
    checks++;
    if (pred_idx !== m_hist) begin
      errors++;
      $display("FAIL %s pred_idx actual=%0d expected=%0d", req, pred_idx, m_hist);
    end
    checks++;
    if (pred_taken !== exp_pred(m_ctr[m_hist])) begin
      errors++;
      $display("FAIL %s pred_taken actual=%0b expected=%0b", req, pred_taken,
               exp_pred(m_ctr[m_hist]));
    end
  endtask

  // Drive at a negedge, model the edge, check at the following negedge
  task automatic step(logic [1:0] hv, logic [1:0] ht, bit rv, bit rt, string req);
    hist_vld = hv; hist_taken = ht; res_vld = rv; res_taken = rt;
    @(posedge clk);
    if (rv) m_ctr[m_hist] = sat_next(m_ctr[m_hist], rt);
    for (int k = 0; k < 2; k++) if (hv[k]) m_hist[k] = ht[k];
    @(negedge clk);
    hist_vld = '0; res_vld = 1'b0;
    chk(req);
  endtask

  task automatic set_hist(logic [1:0] h, string req);
    step(2'b11, h, 1'b0, 1'b0, req);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    errors = 0; checks = 0; finished = 0;
    rst_n = 1'b0; hist_vld = '0; hist_taken = '0; res_vld = 0; res_taken = 0;
    for (int i = 0; i < 4; i++) m_ctr[i] = 1;
    m_hist = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1");

    // R1/R4: every counter starts weakly not taken
    for (int i = 0; i < 4; i++) set_hist(2'(i), "R1");

    // R2: index mapping follows the two outcome bits
    set_hist(2'b01, "R2");
    step(2'b10, 2'b10, 1'b0, 1'b0, "R2");
    step(2'b01, 2'b00, 1'b0, 1'b0, "R2");

    // R5/R9: train counter 2 up past saturation
    set_hist(2'b10, "R2");
    step(2'b00, 2'b00, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 4; i++) step(2'b00, 2'b00, 1'b1, 1'b1, "R5");
    step(2'b00, 2'b00, 1'b1, 1'b0, "R5");
    step(2'b00, 2'b00, 1'b1, 1'b0, "R5");

    // R7: other counters untouched
    for (int i = 0; i < 4; i++) set_hist(2'(i), "R7");

    // R6: drive counter 0 below zero, then back up
    set_hist(2'b00, "R6");
    for (int i = 0; i < 3; i++) step(2'b00, 2'b00, 1'b1, 1'b0, "R6");
    step(2'b00, 2'b00, 1'b1, 1'b1, "R6");
    step(2'b00, 2'b00, 1'b1, 1'b1, "R6");
    step(2'b00, 2'b00, 1'b1, 1'b0, "R6");

    // R8: history change and resolve on the same edge
    step(2'b11, 2'b11, 1'b1, 1'b1, "R8");
    set_hist(2'b00, "R8");
    set_hist(2'b11, "R8");

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] hv;
      logic [1:0] ht;
      bit rv;
      bit rt;
      hv = 2'($urandom % 4);
      ht = 2'($urandom % 4);
      rv = 1'($urandom % 2);
      rt = 1'($urandom % 2);
      step(hv, ht, rv, rt, "R3");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule